// File: doc/BRIEF.md
# Bus-Write to Dual DAC Sample Bridge

This block sits between the asynchronous external memory port of a processor and a two-channel DAC. A DMA engine in the processor pushes one 32-bit word per bus write. Each word holds an I sample and a Q sample, 16 bits each. The bridge watches the active-low write strobe, captures the word and answers with a one-cycle ready pulse that closes the bus cycle. It then holds the pair in a single staging register until the next DAC update.

DAC updates come from a free-running divider on the bus clock. The DAC rate is therefore an exact integer fraction of the bus clock, and no FIFO is needed. On each update the staged pair is moved into both DAC output registers together. Each channel keeps the most significant DAC-width bits of its 16-bit sample.

The block has two sticky error flags:
- The underrun flag is set when an update finds no fresh pair.
- The overwrite flag is set when a new word replaces a pair that has not yet been used.

Top module: `dacwr_bridge`

## Requirements
- R1: When the write strobe `bus_we_n` is first sampled low by the handshake in its idle state, `bus_rdy` goes high on the next rising edge. It stays high for exactly one cycle. The word on `bus_data` is captured on that same edge.
- R2: Once ready has been given, no further word is captured and ready stays low until the strobe has been sampled high. Holding the strobe low therefore produces exactly one capture.
- R3: The I sample is `bus_data[15:0]` and the Q sample is `bus_data[31:16]`. Each DAC output takes the upper DAC_W bits of its sample: bits 15 down to 16-DAC_W.
- R4: `dac_upd` is a one-cycle pulse that repeats every DIV_N bus clock cycles. It is high in the cycle in which new DAC values first appear.
- R5: On an update, a pending pair is moved to `dac_i`/`dac_q` and stops being pending. The DAC outputs never change except with an update pulse or reset.
- R6: An update with no word captured since the previous update leaves both outputs unchanged and sets `underrun`. The flag stays set until reset.
- R7: A capture while an unused pair is pending replaces that pair, so only the newer pair reaches the DAC. It also sets `overwrite`, which stays set until reset.
- R8: A capture on the same edge as an update is not an overwrite. The update takes the older pending pair and the new word becomes pending.
- R9: During reset both DAC outputs are mid-scale (only bit DAC_W-1 set). `underrun`, `overwrite`, `bus_rdy` and `dac_upd` are all low.
- R10: `bus_data` is ignored whenever no capture is taking place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all logic is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we_n | input | 1 | Active-low write strobe from the bus master |
| bus_data | input | 32 | Write data: Q in the upper half, I in the lower half |
| bus_rdy | output | 1 | One-cycle ready pulse that completes the write |
| dac_i | output | DAC_W | I channel DAC code |
| dac_q | output | DAC_W | Q channel DAC code |
| dac_upd | output | 1 | Sample-enable pulse marking a DAC update |
| underrun | output | 1 | Sticky: an update found no fresh pair |
| overwrite | output | 1 | Sticky: a pending pair was replaced before use |

## Verification
The hardest case to reach is a capture that falls on exactly the same edge as a DAC update (R8). The port timing gives no direct handle on the divider phase, so the stimulus derives it. The stimulus locks onto an observed `dac_upd` pulse and counts bus cycles from there. It stages one pair early in the period. It then starts a second write so that the capture lands on the next update edge. After that, `overwrite` must still be low, and the two following updates must deliver the two pairs in order. Underrun and overwrite are reached by skipping a period and by writing twice within one period.

// File: rtl/dacwr_pkg.sv
package dacwr_pkg;

   // Bus write handshake phases, in the order they are visited.
   typedef enum logic [1:0] {
      HS_IDLE = 2'd0,
      HS_CAPT = 2'd1,
      HS_ACK  = 2'd2,
      HS_REL  = 2'd3
   } hs_state_t;

   localparam int SAMPLE_W = 16;
   localparam int LANES    = 2;

endpackage

// File: rtl/dacwr_hshake.sv
module dacwr_hshake
   import dacwr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic bus_we_n,
   output logic capture,
   output logic bus_rdy
);

   hs_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         HS_IDLE: if (!bus_we_n) state_d = HS_CAPT;
         HS_CAPT: state_d = HS_ACK;
         HS_ACK:  state_d = HS_REL;
         HS_REL:  if (bus_we_n) state_d = HS_IDLE;
         default: state_d = HS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= HS_IDLE;
      else        state_q <= state_d;
   end

   // The word is taken on the edge that leaves the capture phase, the
   // same edge that raises ready.
   assign capture = (state_q == HS_CAPT);
   assign bus_rdy = (state_q == HS_ACK);

   assert_rdy_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdy |=> !bus_rdy);

   assert_rdy_after_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_rdy) |-> $past(!bus_we_n));

   assert_capture_then_rdy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (bus_rdy && !capture));

endmodule

// File: rtl/dacwr_rate.sv
module dacwr_rate #(
   parameter int DIV_N = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   localparam int CW = (DIV_N > 2) ? $clog2(DIV_N) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV_N - 1);

   if (DIV_N < 2) begin : g_bad_div
      $error("dacwr_rate: DIV_N must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (cnt_q == LAST)  cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   assign tick = (cnt_q == LAST);

   assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

endmodule

// File: rtl/dacwr_unpack.sv
module dacwr_unpack
   import dacwr_pkg::*;
#(
   parameter int DAC_W = 14
) (
   input  logic [LANES*SAMPLE_W-1:0]  word,
   output logic [LANES-1:0][DAC_W-1:0] lane
);

   localparam int DROP = SAMPLE_W - DAC_W;

   if (DAC_W < 1 || DAC_W > SAMPLE_W) begin : g_bad_width
      $error("dacwr_unpack: DAC_W must lie in 1..16");
   end

   for (genvar c = 0; c < LANES; c++) begin : g_lane
      logic [SAMPLE_W-1:0] smp;
      assign smp = word[c*SAMPLE_W +: SAMPLE_W];
      if (DROP == 0) begin : g_full
         assign lane[c] = DAC_W'(smp);
      end else begin : g_trunc
         assign lane[c] = DAC_W'(smp >> DROP);
      end
   end

endmodule

// File: rtl/dacwr_bridge.sv
module dacwr_bridge
   import dacwr_pkg::*;
#(
   parameter int DAC_W = 14,
   parameter int DIV_N = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_we_n,
   input  logic [31:0]      bus_data,
   output logic             bus_rdy,
   output logic [DAC_W-1:0] dac_i,
   output logic [DAC_W-1:0] dac_q,
   output logic             dac_upd,
   output logic             underrun,
   output logic             overwrite
);

   localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};

   if (LANES * SAMPLE_W != 32) begin : g_bad_bus
      $error("dacwr_bridge: bus word must hold exactly two samples");
   end

   logic capture;
   logic tick;
   logic [LANES-1:0][DAC_W-1:0] cand;

   dacwr_hshake u_hs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_we_n (bus_we_n),
      .capture  (capture),
      .bus_rdy  (bus_rdy)
   );

   dacwr_rate #(.DIV_N(DIV_N)) u_rate (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   dacwr_unpack #(.DAC_W(DAC_W)) u_unpack (
      .word (bus_data),
      .lane (cand)
   );

   logic [DAC_W-1:0] hold_i, hold_q;
   logic             pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_i    <= MID;
         hold_q    <= MID;
         pending   <= 1'b0;
         dac_i     <= MID;
         dac_q     <= MID;
         dac_upd   <= 1'b0;
         underrun  <= 1'b0;
         overwrite <= 1'b0;
      end else begin
         dac_upd <= tick;
         // Update consumes whatever was staged before this edge.
         if (tick) begin
            if (pending) begin
               dac_i <= hold_i;
               dac_q <= hold_q;
            end else begin
               underrun <= 1'b1;
            end
         end
         if (capture) begin
            hold_i  <= cand[0];
            hold_q  <= cand[1];
            pending <= 1'b1;
            if (pending && !tick) overwrite <= 1'b1;
         end else if (tick) begin
            pending <= 1'b0;
         end
      end
   end

   assert_upd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dac_upd |=> !dac_upd);

   assert_out_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_upd |-> ($stable(dac_i) && $stable(dac_q)));

   assert_underrun_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underrun) |-> (dac_upd && $stable(dac_i) && $stable(dac_q)));

   assert_overwrite_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overwrite) |-> ($past(pending) && $past(capture) && !$past(tick)));

   assert_coincide_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && tick) |=> (pending && dac_upd));

endmodule

// File: tb/dacwr_bridge_test.sv
module dacwr_bridge_test;

   localparam int DAC_W = 14;
   localparam int DIV_N = 16;
   localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we_n = 1'b1;
   logic [31:0] bus_data = '0;
   logic        bus_rdy, dac_upd, underrun, overwrite;
   logic [DAC_W-1:0] dac_i, dac_q;

   always #4 clk = ~clk;

   dacwr_bridge #(.DAC_W(DAC_W), .DIV_N(DIV_N)) uut (
      .clk(clk), .rst_n(rst_n), .bus_we_n(bus_we_n), .bus_data(bus_data),
      .bus_rdy(bus_rdy), .dac_i(dac_i), .dac_q(dac_q), .dac_upd(dac_upd),
      .underrun(underrun), .overwrite(overwrite));

   int checks = 0;
   int fails  = 0;
   logic [2*DAC_W-1:0] expq[$];
   logic [DAC_W-1:0] last_i = MID, last_q = MID;
   logic exp_under = 1'b0, exp_ovf = 1'b0;
   bit   mon_on = 1'b0;
   int   cyc = 0, last_upd = -1;

   task automatic check(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // R3: upper DAC_W bits of each 16-bit half, Q above I.
   function automatic logic [2*DAC_W-1:0] expect_pair(logic [31:0] w);
      logic [DAC_W-1:0] ei, eq;
      ei = w[15 -: DAC_W];
      eq = w[31 -: DAC_W];
      return {eq, ei};
   endfunction

   // Monitor: pops one expected pair per update, or expects a hold.
   always @(negedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
      if (!rst_n) last_upd = -1;
      else if (mon_on && dac_upd) begin
         if (last_upd >= 0)
            check(cyc - last_upd == DIV_N, "R4", "update period", cyc - last_upd, DIV_N);
         last_upd = cyc;
         if (expq.size() > 0) begin
            logic [2*DAC_W-1:0] e;
            e = expq.pop_front();
            check(dac_i == e[DAC_W-1:0], "R3/R5", "dac_i", dac_i, e[DAC_W-1:0]);
            check(dac_q == e[2*DAC_W-1:DAC_W], "R3/R5", "dac_q", dac_q, e[2*DAC_W-1:DAC_W]);
            last_i = e[DAC_W-1:0];
            last_q = e[2*DAC_W-1:DAC_W];
         end else begin
            exp_under = 1'b1;
            check(dac_i == last_i && dac_q == last_q, "R6", "held pair",
                  {dac_q, dac_i}, {last_q, last_i});
         end
         check(underrun == exp_under, "R6", "underrun", underrun, exp_under);
         check(overwrite == exp_ovf, "R7", "overwrite", overwrite, exp_ovf);
      end
   end

   task automatic wait_upd();
      do @(negedge clk); while (!dac_upd);
   endtask

   // Driver: one bus write, optionally holding the strobe after ready.
   task automatic write_word(logic [31:0] w, int extra);
      bus_we_n = 1'b0;
      bus_data = w;
      @(negedge clk);
      check(bus_rdy == 1'b0, "R1", "ready before capture", bus_rdy, 0);
      @(negedge clk);
      check(bus_rdy == 1'b1, "R1", "ready pulse", bus_rdy, 1);
      for (int k = 0; k < extra; k++) begin
         @(negedge clk);
         check(bus_rdy == 1'b0, "R2", "no ready while strobe held", bus_rdy, 0);
      end
      bus_we_n = 1'b1;
      bus_data = ~w;   // R10: junk on the bus with the strobe high
      @(negedge clk);
      check(bus_rdy == 1'b0, "R2", "ready released", bus_rdy, 0);
      @(negedge clk);
      check(overwrite == exp_ovf, "R10", "no stray capture", overwrite, exp_ovf);
   endtask

   initial begin
      logic [31:0] wa, wb;
      repeat (3) @(negedge clk);
      check(dac_i == MID && dac_q == MID, "R9", "reset mid-scale", {dac_q, dac_i}, {MID, MID});
      check(!underrun && !overwrite, "R9", "reset flags", {underrun, overwrite}, 0);
      check(!bus_rdy && !dac_upd, "R9", "reset strobes", {bus_rdy, dac_upd}, 0);

      @(posedge clk);
      #1 rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge clk);
      write_word(32'h1357_9BDF, 0);
      expq.push_back(expect_pair(32'h1357_9BDF));

      // Main function under several data patterns and strobe lengths.
      for (int k = 0; k < 6; k++) begin
         logic [31:0] w;
         case (k)
            0: w = 32'hFFFF_0000;
            1: w = 32'h0000_FFFF;
            2: w = 32'h8001_7FFE;
            default: w = 32'h1234_5678 ^ (32'(k) * 32'h9E37_79B9);
         endcase
         wait_upd();
         @(negedge clk);
         write_word(w, k % 3);
         expq.push_back(expect_pair(w));
      end

      // R8: second capture lands on the update edge.
      wa = 32'hA5A5_5A5A;
      wb = 32'h0F0F_F0F0;
      wait_upd();
      @(negedge clk);
      write_word(wa, 0);
      expq.push_back(expect_pair(wa));
      repeat (9) @(negedge clk);
      expq.push_back(expect_pair(wb));
      write_word(wb, 0);
      check(overwrite == 1'b0, "R8", "coincident capture not overwrite", overwrite, 0);
      wait_upd();
      check({dac_q, dac_i} == expect_pair(wb), "R8", "newer pair follows", {dac_q, dac_i},
            expect_pair(wb));

      // R6: skip a period.
      wait_upd();
      check(underrun == 1'b1, "R6", "underrun after skipped period", underrun, 1);
      check({dac_q, dac_i} == expect_pair(wb), "R6", "pair held", {dac_q, dac_i},
            expect_pair(wb));

      // R7: two writes within one period.
      wait_upd();
      @(negedge clk);
      write_word(32'hDEAD_BEEF, 0);
      exp_ovf = 1'b1;
      write_word(32'h2468_ACE0, 1);
      expq.push_back(expect_pair(32'h2468_ACE0));
      check(overwrite == 1'b1, "R7", "overwrite flag", overwrite, 1);
      wait_upd();
      check({dac_q, dac_i} == expect_pair(32'h2468_ACE0), "R7", "latest pair kept",
            {dac_q, dac_i}, expect_pair(32'h2468_ACE0));
      wait_upd();

      // R9: reset again in mid-run.
      mon_on = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(dac_i == MID && dac_q == MID, "R9", "re-reset mid-scale", {dac_q, dac_i}, {MID, MID});
      check(!underrun && !overwrite, "R9", "re-reset flags", {underrun, overwrite}, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule